// File: doc/BRIEF.md
# Rename Map with Guarded Result Writeback

This block keeps, for every architectural register of an out-of-order core, either the register's committed-to-file value or the tag of the reservation station that will produce its next value. When an instruction issues, the block reads both of its source registers. Each read returns a value with tag 0 when the file copy is current, or a non-zero producer tag with value 0 when a station still owes the result. In the same cycle the block binds the instruction's destination register to the station tag just allocated for it. A tag value of 0 is reserved to mean "no pending producer", so station tags run from 1 to `NUM_STATIONS`.

The block listens to the single result bus. Each cycle at most one (tag, value) pair is broadcast. A register takes the broadcast value only if its entry still names that tag, and the entry then empties. A result whose register has since been rebound to a younger producer is dropped. The map itself never copies values: a value moves into the file only when it is broadcast. A source read made in the same cycle as a matching broadcast forwards the bus value. Register 0 can be built as a constant zero that never takes a binding.

Top module: `reg_status_table`

## Requirements
- R1: After reset every entry is empty and every register holds 0, so a read of any register returns value 0 and tag 0.
- R2: A read of a register whose entry is empty (tag 0) returns the register's stored value with tag 0.
- R3: A read of a register whose entry holds a non-zero tag, with no matching broadcast in that cycle, returns that tag and value 0.
- R4: An issue with a destination (`iss_valid` and `iss_dst_valid` high) writes `iss_tag` into the destination's entry at the next clock edge. This happens even when the entry already holds an older pending tag.
- R5: A broadcast (`cdb_valid` high) whose tag equals a register's non-zero entry writes the bus value into that register and empties the entry at the same clock edge. At most one entry matches any broadcast.
- R6: A broadcast whose tag matches no entry, including the tag of a producer that was superseded by a later binding, changes no register value and no entry.
- R7: When an issue rebinds a register in the same cycle as a broadcast that matches the register's old tag, the register ends up bound to the new tag and its stored value is not written.
- R8: A read made in the same cycle as a broadcast whose tag equals the read register's non-zero entry returns the bus value with tag 0.
- R9: With `ZERO_REG` set, register 0 always reads as value 0 and tag 0. A binding to it is ignored, and so is a broadcast.
- R10: Source reads in an issue cycle see the mapping from before that cycle's binding, so a source equal to the destination returns the older state.
- R11: With `cdb_valid` low, the bus tag and value have no effect on any entry or register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_src_a | input | REG_W | First source register index |
| iss_src_b | input | REG_W | Second source register index |
| iss_dst_valid | input | 1 | The issuing instruction writes a destination |
| iss_dst | input | REG_W | Destination register index |
| iss_tag | input | TAG_W | Non-zero station tag allocated to the issuing instruction |
| cdb_valid | input | 1 | A result is broadcast this cycle |
| cdb_tag | input | TAG_W | Tag of the broadcasting station |
| cdb_value | input | DATA_W | Broadcast result value |
| src_a_value | output | DATA_W | First source value (0 when pending) |
| src_a_tag | output | TAG_W | First source producer tag (0 when value is valid) |
| src_b_value | output | DATA_W | Second source value (0 when pending) |
| src_b_tag | output | TAG_W | Second source producer tag (0 when value is valid) |

## Verification
A corrupted entry shows up at the read ports in the very next cycle the register is read. A stale tag makes a consumer wait for a broadcast that will never match. A wrongly cleared entry hands out a value that is not the newest result. A missed guard lets a superseded result overwrite a register. That error stays hidden while the register is still pending, and it shows as a wrong value once the register reads as ready. The directed scenarios therefore read every affected register both right after each broadcast and after the final broadcast of a chain of bindings. They also read unrelated registers to catch writes that land on the wrong entry.

// File: rtl/rst_pkg.sv
package rst_pkg;

   // How a source read is resolved in a given cycle.
   typedef enum logic [1:0] {
      SRC_READY   = 2'd0,   // entry empty, file value is current
      SRC_BYPASS  = 2'd1,   // entry pending, bus carries its result now
      SRC_PENDING = 2'd2    // entry pending, result not yet broadcast
   } src_kind_e;

   // Width needed for station tags when code 0 means "no producer".
   function automatic int tag_width(input int stations);
      return $clog2(stations + 1);
   endfunction

endpackage

// File: rtl/rst_entry.sv
// One register slot: producer tag plus stored value, updated by
// a destination binding or by a matching result broadcast.
module rst_entry #(
   parameter int DATA_W = 32,
   parameter int TAG_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bind_en,
   input  logic [TAG_W-1:0]  bind_tag,
   input  logic              cdb_valid,
   input  logic [TAG_W-1:0]  cdb_tag,
   input  logic [DATA_W-1:0] cdb_value,
   output logic [TAG_W-1:0]  stat_q,
   output logic [DATA_W-1:0] data_q
);

   logic pending;
   logic hit;

   assign pending = (stat_q != '0);
   assign hit     = cdb_valid && pending && (stat_q == cdb_tag);

   // A binding in the same cycle wins over a broadcast hit: the
   // result is then already superseded, so the file keeps its value.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         data_q <= '0;
      end else if (bind_en) begin
         stat_q <= bind_tag;
      end else if (hit) begin
         stat_q <= '0;
         data_q <= cdb_value;
      end
   end

endmodule

// File: rtl/rst_lookup.sv
// One source read port with same-cycle forwarding from the result bus.
module rst_lookup
   import rst_pkg::*;
#(
   parameter int NUM_REGS = 16,
   parameter int DATA_W   = 32,
   parameter int TAG_W    = 3,
   localparam int REG_W   = $clog2(NUM_REGS)
) (
   input  logic [REG_W-1:0]                src,
   input  logic [NUM_REGS-1:0][TAG_W-1:0]  stat_vec,
   input  logic [NUM_REGS-1:0][DATA_W-1:0] data_vec,
   input  logic                            cdb_valid,
   input  logic [TAG_W-1:0]                cdb_tag,
   input  logic [DATA_W-1:0]               cdb_value,
   output logic [DATA_W-1:0]               value,
   output logic [TAG_W-1:0]                tag
);

   logic [TAG_W-1:0]  sel_tag;
   logic [DATA_W-1:0] sel_data;
   src_kind_e         kind;

   assign sel_tag  = stat_vec[src];
   assign sel_data = data_vec[src];

   always_comb begin
      if (sel_tag == '0)
         kind = SRC_READY;
      else if (cdb_valid && (cdb_tag == sel_tag))
         kind = SRC_BYPASS;
      else
         kind = SRC_PENDING;
   end

   always_comb begin
      unique case (kind)
         SRC_READY: begin
            value = sel_data;
            tag   = '0;
         end
         SRC_BYPASS: begin
            value = cdb_value;
            tag   = '0;
         end
         default: begin
            value = '0;
            tag   = sel_tag;
         end
      endcase
   end

endmodule

// File: rtl/reg_status_table.sv
// Rename map and register file with tag-guarded result writeback.
module reg_status_table #(
   parameter int  NUM_REGS     = 16,
   parameter int  NUM_STATIONS = 7,
   parameter int  DATA_W       = 32,
   parameter bit  ZERO_REG     = 1'b1,
   localparam int REG_W        = $clog2(NUM_REGS),
   localparam int TAG_W        = rst_pkg::tag_width(NUM_STATIONS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_valid,
   input  logic [REG_W-1:0]  iss_src_a,
   input  logic [REG_W-1:0]  iss_src_b,
   input  logic              iss_dst_valid,
   input  logic [REG_W-1:0]  iss_dst,
   input  logic [TAG_W-1:0]  iss_tag,
   input  logic              cdb_valid,
   input  logic [TAG_W-1:0]  cdb_tag,
   input  logic [DATA_W-1:0] cdb_value,
   output logic [DATA_W-1:0] src_a_value,
   output logic [TAG_W-1:0]  src_a_tag,
   output logic [DATA_W-1:0] src_b_value,
   output logic [TAG_W-1:0]  src_b_tag
);

   // ---------------- elaboration-time parameter checks ----------------
   if (NUM_REGS < 2) begin : g_bad_nregs
      $error("reg_status_table: NUM_REGS must be at least 2");
   end
   if ((1 << REG_W) != NUM_REGS) begin : g_bad_pow2
      $error("reg_status_table: NUM_REGS must be a power of two");
   end
   if (NUM_STATIONS < 1) begin : g_bad_st
      $error("reg_status_table: NUM_STATIONS must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("reg_status_table: DATA_W must be at least 1");
   end

   // ---------------- per-register state ----------------
   logic [NUM_REGS-1:0][TAG_W-1:0]  stat_vec;
   logic [NUM_REGS-1:0][DATA_W-1:0] data_vec;

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      if (ZERO_REG && (r == 0)) begin : g_const
         // Constant zero register: no storage, never bound.
         assign stat_vec[r] = '0;
         assign data_vec[r] = '0;
      end else begin : g_slot
         logic bind_en;
         assign bind_en = iss_valid && iss_dst_valid && (iss_dst == REG_W'(r));

         rst_entry #(
            .DATA_W (DATA_W),
            .TAG_W  (TAG_W)
         ) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .bind_en   (bind_en),
            .bind_tag  (iss_tag),
            .cdb_valid (cdb_valid),
            .cdb_tag   (cdb_tag),
            .cdb_value (cdb_value),
            .stat_q    (stat_vec[r]),
            .data_q    (data_vec[r])
         );
      end
   end

   // ---------------- source read ports ----------------
   rst_lookup #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .TAG_W    (TAG_W)
   ) u_look_a (
      .src       (iss_src_a),
      .stat_vec  (stat_vec),
      .data_vec  (data_vec),
      .cdb_valid (cdb_valid),
      .cdb_tag   (cdb_tag),
      .cdb_value (cdb_value),
      .value     (src_a_value),
      .tag       (src_a_tag)
   );

   rst_lookup #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .TAG_W    (TAG_W)
   ) u_look_b (
      .src       (iss_src_b),
      .stat_vec  (stat_vec),
      .data_vec  (data_vec),
      .cdb_valid (cdb_valid),
      .cdb_tag   (cdb_tag),
      .cdb_value (cdb_value),
      .value     (src_b_value),
      .tag       (src_b_tag)
   );

endmodule

// File: rtl/rst_chk.sv
// Property checker attached to the rename map.
module rst_chk #(
   parameter int  NUM_REGS = 16,
   parameter int  DATA_W   = 32,
   parameter int  TAG_W    = 3,
   parameter bit  ZERO_REG = 1'b1,
   localparam int REG_W    = $clog2(NUM_REGS)
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            iss_valid,
   input logic [REG_W-1:0]                iss_src_a,
   input logic [REG_W-1:0]                iss_src_b,
   input logic                            iss_dst_valid,
   input logic [REG_W-1:0]                iss_dst,
   input logic [TAG_W-1:0]                iss_tag,
   input logic                            cdb_valid,
   input logic [TAG_W-1:0]                cdb_tag,
   input logic [DATA_W-1:0]               cdb_value,
   input logic [DATA_W-1:0]               src_a_value,
   input logic [TAG_W-1:0]                src_a_tag,
   input logic [DATA_W-1:0]               src_b_value,
   input logic [TAG_W-1:0]                src_b_tag,
   input logic [NUM_REGS-1:0][TAG_W-1:0]  stat_vec,
   input logic [NUM_REGS-1:0][DATA_W-1:0] data_vec
);

   logic [NUM_REGS-1:0] hit_v;

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_r
      logic bind_r;
      assign bind_r   = iss_valid && iss_dst_valid && (iss_dst == REG_W'(r))
                        && !(ZERO_REG && (r == 0));
      assign hit_v[r] = cdb_valid && (stat_vec[r] != '0) && (stat_vec[r] == cdb_tag);

      // R4 R7
      bind_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         bind_r |=> (stat_vec[r] == $past(iss_tag)) && (data_vec[r] == $past(data_vec[r])));

      // R5
      hit_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (hit_v[r] && !bind_r) |=> (stat_vec[r] == '0) && (data_vec[r] == $past(cdb_value)));

      // R6 R11
      quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!hit_v[r] && !bind_r) |=> $stable(stat_vec[r]) && $stable(data_vec[r]));
   end

   // R5
   single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_v));

   // R4
   nonzero_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_dst_valid) |-> (iss_tag != '0));

   // R8
   a_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_v[iss_src_a] |-> (src_a_tag == '0) && (src_a_value == cdb_value));

   // R8
   b_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_v[iss_src_b] |-> (src_b_tag == '0) && (src_b_value == cdb_value));

   // R3
   a_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_vec[iss_src_a] != '0) && !hit_v[iss_src_a])
      |-> (src_a_tag == stat_vec[iss_src_a]) && (src_a_value == '0));

   // R2
   b_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_vec[iss_src_b] == '0)
      |-> (src_b_tag == '0) && (src_b_value == data_vec[iss_src_b]));

   // R9
   zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ZERO_REG && (iss_src_a == '0)) |-> (src_a_tag == '0) && (src_a_value == '0));

endmodule

bind reg_status_table rst_chk #(
   .NUM_REGS (NUM_REGS),
   .DATA_W   (DATA_W),
   .TAG_W    (TAG_W),
   .ZERO_REG (ZERO_REG)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .iss_valid     (iss_valid),
   .iss_src_a     (iss_src_a),
   .iss_src_b     (iss_src_b),
   .iss_dst_valid (iss_dst_valid),
   .iss_dst       (iss_dst),
   .iss_tag       (iss_tag),
   .cdb_valid     (cdb_valid),
   .cdb_tag       (cdb_tag),
   .cdb_value     (cdb_value),
   .src_a_value   (src_a_value),
   .src_a_tag     (src_a_tag),
   .src_b_value   (src_b_value),
   .src_b_tag     (src_b_tag),
   .stat_vec      (stat_vec),
   .data_vec      (data_vec)
);

// File: tb/reg_status_table_tb.sv
module reg_status_table_tb;

   localparam int NR = 16;
   localparam int NS = 7;
   localparam int DW = 32;
   localparam int RW = 4;
   localparam int TW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          iss_valid;
   logic [RW-1:0] iss_src_a;
   logic [RW-1:0] iss_src_b;
   logic          iss_dst_valid;
   logic [RW-1:0] iss_dst;
   logic [TW-1:0] iss_tag;
   logic          cdb_valid;
   logic [TW-1:0] cdb_tag;
   logic [DW-1:0] cdb_value;
   logic [DW-1:0] src_a_value;
   logic [TW-1:0] src_a_tag;
   logic [DW-1:0] src_b_value;
   logic [TW-1:0] src_b_tag;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   reg_status_table #(
      .NUM_REGS     (NR),
      .NUM_STATIONS (NS),
      .DATA_W       (DW),
      .ZERO_REG     (1'b1)
   ) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .iss_valid     (iss_valid),
      .iss_src_a     (iss_src_a),
      .iss_src_b     (iss_src_b),
      .iss_dst_valid (iss_dst_valid),
      .iss_dst       (iss_dst),
      .iss_tag       (iss_tag),
      .cdb_valid     (cdb_valid),
      .cdb_tag       (cdb_tag),
      .cdb_value     (cdb_value),
      .src_a_value   (src_a_value),
      .src_a_tag     (src_a_tag),
      .src_b_value   (src_b_value),
      .src_b_tag     (src_b_tag)
   );

   // ---------------- helpers ----------------
   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      iss_valid     = 1'b0;
      iss_dst_valid = 1'b0;
      iss_dst       = '0;
      iss_tag       = '0;
      cdb_valid     = 1'b0;
      cdb_tag       = '0;
      cdb_value     = '0;
   endtask

   task automatic check(input string req, input string port,
                        input logic [DW-1:0] av, input logic [DW-1:0] ev,
                        input logic [TW-1:0] at, input logic [TW-1:0] et);
      checks++;
      if ((av !== ev) || (at !== et)) begin
         errors++;
         $display("FAIL %s %s: actual value=%h tag=%0d, expected value=%h tag=%0d",
                  req, port, av, at, ev, et);
      end
   endtask

   // Read one register on both ports; outputs settle within the delay.
   task automatic read_reg(input string req, input logic [RW-1:0] r,
                           input logic [DW-1:0] ev, input logic [TW-1:0] et);
      iss_src_a = r;
      iss_src_b = r;
      #1;
      check(req, "port a", src_a_value, ev, src_a_tag, et);
      check(req, "port b", src_b_value, ev, src_b_tag, et);
   endtask

   task automatic issue(input logic [RW-1:0] dst, input logic [TW-1:0] tag);
      iss_valid = 1'b1; iss_dst_valid = 1'b1; iss_dst = dst; iss_tag = tag;
      tick();
      iss_valid = 1'b0; iss_dst_valid = 1'b0;
   endtask

   task automatic bcast(input logic [TW-1:0] tag, input logic [DW-1:0] val);
      cdb_valid = 1'b1; cdb_tag = tag; cdb_value = val;
      tick();
      cdb_valid = 1'b0;
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      for (int r = 0; r < NR; r++) read_reg("R1", RW'(r), '0, '0);
   endtask

   task automatic t_bind_write();
      issue(4'd3, 3'd2);
      read_reg("R3 R4", 4'd3, '0, 3'd2);
      cdb_valid = 1'b1; cdb_tag = 3'd2; cdb_value = 32'hAAAA_0003;
      read_reg("R8", 4'd3, 32'hAAAA_0003, '0);
      tick();
      cdb_valid = 1'b0;
      read_reg("R5 R2", 4'd3, 32'hAAAA_0003, '0);
   endtask

   task automatic t_waw();
      issue(4'd5, 3'd1);
      read_reg("R4", 4'd5, '0, 3'd1);
      issue(4'd5, 3'd4);
      read_reg("R4", 4'd5, '0, 3'd4);
      bcast(3'd1, 32'h1111_1111);       // superseded producer
      read_reg("R6", 4'd5, '0, 3'd4);
      read_reg("R6", 4'd3, 32'hAAAA_0003, '0);
      bcast(3'd4, 32'h4444_4444);
      read_reg("R5", 4'd5, 32'h4444_4444, '0);
   endtask

   task automatic t_race();
      issue(4'd6, 3'd3);
      bcast(3'd3, 32'h3333_3333);
      read_reg("R5", 4'd6, 32'h3333_3333, '0);
      issue(4'd6, 3'd5);
      iss_valid = 1'b1; iss_dst_valid = 1'b1; iss_dst = 4'd6; iss_tag = 3'd6;
      cdb_valid = 1'b1; cdb_tag = 3'd5; cdb_value = 32'h5555_5555;
      tick();
      idle();
      read_reg("R7", 4'd6, '0, 3'd6);
      bcast(3'd6, 32'h6666_6666);
      read_reg("R7", 4'd6, 32'h6666_6666, '0);
   endtask

   task automatic t_src_is_dst();
      iss_valid = 1'b1; iss_dst_valid = 1'b1; iss_dst = 4'd3; iss_tag = 3'd7;
      read_reg("R10", 4'd3, 32'hAAAA_0003, '0);
      tick();
      idle();
      read_reg("R4", 4'd3, '0, 3'd7);
      cdb_valid = 1'b1; cdb_tag = 3'd7; cdb_value = 32'h7777_7777;
      read_reg("R8", 4'd3, 32'h7777_7777, '0);
      tick();
      idle();
      read_reg("R5", 4'd3, 32'h7777_7777, '0);
   endtask

   task automatic t_zero_reg();
      issue(4'd0, 3'd2);
      read_reg("R9", 4'd0, '0, '0);
      bcast(3'd2, 32'hDEAD_BEEF);
      read_reg("R9", 4'd0, '0, '0);
   endtask

   task automatic t_bus_idle();
      issue(4'd8, 3'd1);
      cdb_valid = 1'b0; cdb_tag = 3'd1; cdb_value = 32'h1234_5678;
      tick();
      idle();
      read_reg("R11", 4'd8, '0, 3'd1);
      bcast(3'd1, 32'h8181_8181);
      read_reg("R5", 4'd8, 32'h8181_8181, '0);
   endtask

   task automatic t_two_pending();
      issue(4'd9, 3'd2);
      issue(4'd10, 3'd3);
      bcast(3'd3, 32'hA0A0_A0A0);
      read_reg("R6", 4'd9, '0, 3'd2);
      read_reg("R5", 4'd10, 32'hA0A0_A0A0, '0);
      bcast(3'd2, 32'h9090_9090);
      read_reg("R5", 4'd9, 32'h9090_9090, '0);
      read_reg("R6", 4'd10, 32'hA0A0_A0A0, '0);
   endtask

   // ---------------- main sequence ----------------
   initial begin
      idle();
      iss_src_a = '0;
      iss_src_b = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      tick();
      t_reset();
      tick();
      t_bind_write();
      t_waw();
      t_race();
      t_src_is_dst();
      t_zero_reg();
      t_bus_idle();
      t_two_pending();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog (all requirements): actual=hung, expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule